// File: doc/BRIEF.md
# Arithmetic Status Trap Generator

This block sits beside a multiply-accumulate unit and turns its four status flags (carry, overflow, extension and limit) into a hardware trap request for the processor pipeline. The flags live in a small status register. That register loads either from the arithmetic unit's per-instruction update or from a software write. A control register holds one mask bit per flag and a global enable bit. When an unmasked flag is set while the enable is on, the block sets a sticky request bit in the status register and a trap flag bit. Both bits stay set until software clears them.

The trap does not reach the pipeline at once. A short shift register models the trap-insertion slots: it advances only on an instruction-cycle strobe, and a one-cycle take pulse comes out after three strobes. If a handler returns without clearing the sticky bit while the cause persists, nothing new fires. Clearing the sticky bit while the cause is still present re-arms the request and produces a fresh trap. The trap number reported with the request is fixed at 0xA.

Top module: `mac_status_trap`

## Requirements
- R1: A synchronous active-high reset clears the control register, the status register (flags and sticky bit), the trap flag bit, the latency pipeline and the take output.
- R2: The status flags are bits 0 (carry), 1 (overflow), 2 (extension) and 3 (limit), and control bits 0..3 are their masks in the same order. A flag can raise a request only when its own mask bit is 1.
- R3: Control bit 4 is the global enable. While it is 0, no request is raised, whatever the flags and masks hold.
- R4: A request sets the sticky bit (status bit 4) and the trap flag bit on the next clock edge, both together.
- R5: Writing the status register with bit 4 set clears the sticky bit, and pulsing the trap-clear input clears the trap flag bit. Either bit otherwise holds its value. When a request is raised in the same cycle as a clear, the set wins.
- R6: When software clears the sticky bit while the qualified condition still holds, a new request is raised. The sticky bit is set again and a new take pulse follows.
- R7: A software write to the status register loads flags from write-data bits 3..0 and raises requests exactly as an arithmetic update does. When both arrive in the same cycle, the software write wins.
- R8: A request is held until the next strobe cycle. After the third strobe-qualified clock edge, counting the edge that captures it, the take output is high for exactly one cycle. With the strobe held high, take is high in the third cycle after the request cycle.
- R9: The trap code output is constant 0xA.
- R10: A condition that stays true while the sticky bit is set raises no further request. A fresh rising of the condition raises a new request even while the sticky bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction-cycle strobe that advances the latency pipeline |
| mac_upd | input | 1 | Arithmetic unit flag update strobe |
| mac_flags | input | 4 | Flag values from the arithmetic unit |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 5 | Control write data: masks 3..0, enable 4 |
| ctl_q | output | 5 | Control register contents |
| stat_we | input | 1 | Status register write enable |
| stat_wdata | input | 5 | Status write data: flags 3..0, bit 4 clears the sticky bit |
| stat_q | output | 5 | Status register: flags 3..0, sticky request bit 4 |
| tfr_clr | input | 1 | Clears the trap flag bit |
| trap_bit | output | 1 | Sticky trap flag bit |
| trap_take | output | 1 | One-cycle pulse when the trap enters the pipeline |
| trap_code | output | 4 | Trap number, 0xA |

## Verification
The hardest cases to reach from the ports are those where a software clear collides with a hardware set. The request has to be raised in exactly the cycle the clear is written. The bench sets a flag through an arithmetic update and, in the very next cycle, writes the status clear (keeping the flag) and pulses the trap clear, then checks that both bits stay set. Re-arming is driven the same way. The condition is held, the sticky bit is cleared, and the bench counts the take pulses on an output monitor to confirm that one new trap follows and that none follows while the bit is left set.

// File: rtl/mac_status_trap.sv
module mac_status_trap #(
  parameter int          NFLAG    = 4,
  parameter int          LAT      = 3,
  parameter logic [3:0]  TRAP_NUM = 4'hA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             mac_upd,
  input  logic [NFLAG-1:0] mac_flags,
  input  logic             ctl_we,
  input  logic [NFLAG:0]   ctl_wdata,
  output logic [NFLAG:0]   ctl_q,
  input  logic             stat_we,
  input  logic [NFLAG:0]   stat_wdata,
  output logic [NFLAG:0]   stat_q,
  input  logic             tfr_clr,
  output logic             trap_bit,
  output logic             trap_take,
  output logic [3:0]       trap_code
);
  localparam int PW = LAT - 1;

  logic [NFLAG-1:0] flags, masks;
  logic             enable, mir, trp, cond, cond_q, raise, pend, pend_in, take_q;
  logic [PW-1:0]    pipe;

  assign cond    = enable & |(flags & masks);
  assign raise   = cond & (~cond_q | ~mir);
  assign pend_in = pend | raise;

  always_ff @(posedge clk) begin
    if (rst) begin
      masks  <= '0;
      enable <= 1'b0;
    end else if (ctl_we) begin
      masks  <= ctl_wdata[NFLAG-1:0];
      enable <= ctl_wdata[NFLAG];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          flags <= '0;
    else if (stat_we) flags <= stat_wdata[NFLAG-1:0];
    else if (mac_upd) flags <= mac_flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mir    <= 1'b0;
      trp    <= 1'b0;
      cond_q <= 1'b0;
    end else begin
      mir    <= raise | (mir & ~(stat_we & stat_wdata[NFLAG]));
      trp    <= raise | (trp & ~tfr_clr);
      cond_q <= cond;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      pipe   <= '0;
      take_q <= 1'b0;
    end else begin
      take_q <= step & pipe[PW-1];
      if (step) begin
        pend    <= 1'b0;
        pipe[0] <= pend_in;
        for (int i = 1; i < PW; i++) pipe[i] <= pipe[i-1];
      end else begin
        pend <= pend_in;
      end
    end
  end

  assign ctl_q     = {enable, masks};
  assign stat_q    = {mir, flags};
  assign trap_bit  = trp;
  assign trap_take = take_q;
  assign trap_code = TRAP_NUM;
endmodule

module mac_status_trap_chk #(parameter int NFLAG = 4) (
  input logic           clk,
  input logic           rst,
  input logic           step,
  input logic           stat_we,
  input logic [NFLAG:0] stat_wdata,
  input logic [NFLAG:0] stat_q,
  input logic [NFLAG:0] ctl_q,
  input logic           tfr_clr,
  input logic           trap_bit,
  input logic           trap_take
);
  assert_mask_gate_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[NFLAG]) |-> $past(|(stat_q[NFLAG-1:0] & ctl_q[NFLAG-1:0])));

  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[NFLAG] |=> !$rose(stat_q[NFLAG]));

  assert_bits_together_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q[NFLAG]) |-> trap_bit);

  assert_sticky_hold_R5: assert property (@(posedge clk) disable iff (rst)
    stat_q[NFLAG] && !(stat_we && stat_wdata[NFLAG]) |=> stat_q[NFLAG]);

  assert_trap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    trap_bit && !tfr_clr |=> trap_bit);

  assert_take_on_step_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(trap_take) |-> $past(step));
endmodule

bind mac_status_trap mac_status_trap_chk #(.NFLAG(NFLAG)) u_chk (
  .clk(clk), .rst(rst), .step(step), .stat_we(stat_we), .stat_wdata(stat_wdata),
  .stat_q(stat_q), .ctl_q(ctl_q), .tfr_clr(tfr_clr), .trap_bit(trap_bit),
  .trap_take(trap_take)
);

// File: tb/mac_status_trap_test.sv
module mac_status_trap_test;
  logic clk = 1'b0, rst = 1'b1, step = 1'b1, mac_upd = 1'b0, ctl_we = 1'b0;
  logic stat_we = 1'b0, tfr_clr = 1'b0;
  logic [3:0] mac_flags = '0;
  logic [4:0] ctl_wdata = '0, stat_wdata = '0;
  logic [4:0] ctl_q, stat_q;
  logic trap_bit, trap_take;
  logic [3:0] trap_code;
  int errors = 0, checks = 0, takes = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mac_status_trap uut (
    .clk(clk), .rst(rst), .step(step), .mac_upd(mac_upd), .mac_flags(mac_flags),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .tfr_clr(tfr_clr), .trap_bit(trap_bit), .trap_take(trap_take), .trap_code(trap_code)
  );

  always @(negedge clk) if (!rst && trap_take) takes++;

  // {ctl[4:0], flags[3:0], expected request}
  localparam logic [9:0] VEC [8] = '{
    {5'b10001, 4'b0001, 1'b1}, {5'b01111, 4'b1111, 1'b0},
    {5'b10010, 4'b0001, 1'b0}, {5'b10010, 4'b0010, 1'b1},
    {5'b10100, 4'b0100, 1'b1}, {5'b11000, 4'b1000, 1'b1},
    {5'b11000, 4'b0111, 1'b0}, {5'b10000, 4'b1111, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    ctl_we = 1; ctl_wdata = 0; stat_we = 1; stat_wdata = 5'b10000; tfr_clr = 1;
    nc(1);
    ctl_we = 0; stat_we = 0; tfr_clr = 0;
    nc(4);
  endtask

  task automatic mac_set(input logic [3:0] f);
    mac_upd = 1; mac_flags = f; nc(1); mac_upd = 0;
  endtask

  initial begin
    nc(3);
    chk("R1 ctl", 8'(ctl_q), 0); chk("R1 stat", 8'(stat_q), 0);
    chk("R1 trap", 8'(trap_bit), 0); chk("R1 take", 8'(trap_take), 0);
    chk("R9 code", 8'(trap_code), 8'hA);
    rst = 0; nc(1);

    foreach (VEC[v]) begin
      logic [4:0] c; logic [3:0] f; logic e; int t0;
      {c, f, e} = VEC[v];
      clear_all();
      t0 = takes;
      ctl_we = 1; ctl_wdata = c; nc(1); ctl_we = 0;
      chk("R2 ctl readback", 8'(ctl_q), 8'(c));
      mac_set(f);
      chk("R2 flags", 8'(stat_q[3:0]), 8'(f));
      nc(1);
      chk("R2/R3 sticky", 8'(stat_q[4]), 8'(e));
      chk("R4 trap bit", 8'(trap_bit), 8'(e));
      nc(2);
      chk("R8 take at third cycle", 8'(trap_take), 8'(e));
      nc(1);
      chk("R8 take one cycle", 8'(trap_take), 0);
      chk("R8 take count", 8'(takes - t0), 8'(e));
    end

    // R5: set wins over same-cycle clears
    clear_all();
    ctl_we = 1; ctl_wdata = 5'b10001; nc(1); ctl_we = 0;
    mac_upd = 1; mac_flags = 4'b0001; nc(1); mac_upd = 0;
    stat_we = 1; stat_wdata = 5'b10001; tfr_clr = 1; nc(1);
    stat_we = 0; tfr_clr = 0;
    chk("R5 set beats sticky clear", 8'(stat_q[4]), 1);
    chk("R5 set beats trap clear", 8'(trap_bit), 1);
    nc(6);
    // R10: held condition with sticky set gives no new take
    begin
      int t0; t0 = takes; nc(8);
      chk("R10 no retrigger while held", 8'(takes - t0), 0);
      chk("R10 sticky held", 8'(stat_q[4]), 1);
    end
    // R6: clear sticky while condition holds re-arms
    begin
      int t0; t0 = takes;
      stat_we = 1; stat_wdata = 5'b10001; nc(1); stat_we = 0;
      chk("R6 sticky cleared", 8'(stat_q[4]), 0);
      nc(1);
      chk("R6 sticky re-set", 8'(stat_q[4]), 1);
      nc(3);
      chk("R6 new take", 8'(takes - t0), 1);
    end
    // R5: plain clears
    tfr_clr = 1; nc(1); tfr_clr = 0;
    chk("R5 trap cleared", 8'(trap_bit), 0);
    stat_we = 1; stat_wdata = 5'b10000; nc(1); stat_we = 0;
    chk("R5 sticky cleared", 8'(stat_q[4]), 0);
    nc(3);
    chk("R5 stays clear", 8'(stat_q[4]), 0);
    // R10: fresh rise while sticky set
    mac_set(4'b0001); nc(5);
    begin
      int t0; t0 = takes;
      chk("R10 sticky set", 8'(stat_q[4]), 1);
      mac_set(4'b0000); mac_set(4'b0001); nc(4);
      chk("R10 fresh rise retriggers", 8'(takes - t0), 1);
    end

    // R7: software flag write, and priority over update
    clear_all();
    ctl_we = 1; ctl_wdata = 5'b10010; nc(1); ctl_we = 0;
    stat_we = 1; stat_wdata = 5'b00010; nc(1); stat_we = 0;
    nc(1);
    chk("R7 sw write raises", 8'(stat_q[4]), 1);
    chk("R7 sw write trap bit", 8'(trap_bit), 1);
    nc(4);
    stat_we = 1; stat_wdata = 5'b00100; mac_upd = 1; mac_flags = 4'b0000; nc(1);
    stat_we = 0; mac_upd = 0;
    chk("R7 sw beats update", 8'(stat_q[3:0]), 8'h4);

    // R8: sparse strobe
    clear_all();
    step = 0;
    ctl_we = 1; ctl_wdata = 5'b11000; nc(1); ctl_we = 0;
    begin
      int t0; t0 = takes;
      mac_set(4'b1000); nc(5);
      chk("R8 held without strobe", 8'(takes - t0), 0);
      step = 1; nc(1); step = 0; nc(2);
      step = 1; nc(1); step = 0;
      chk("R8 no take after two strobes", 8'(trap_take), 0);
      nc(2);
      step = 1; nc(1); step = 0;
      chk("R8 take after third strobe", 8'(trap_take), 1);
      nc(1);
      chk("R8 take single cycle", 8'(trap_take), 0);
      chk("R8 one take", 8'(takes - t0), 1);
    end
    step = 1;

    rst = 1; nc(1); rst = 0;
    chk("R1 reset again", 8'({stat_q, trap_bit}), 0);
    chk("R9 code", 8'(trap_code), 8'hA);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule